// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block is a management-bus slave that gives a 16-bit clause-22 MDIO master access to a 32-bit register space inside a switch. The two top bits of the 5-bit PHY address field choose how a frame is handled. One code loads a page register. Another code is a register access, in which the remaining PHY address bits and the 5-bit register field carry the low part of a register address. The page register supplies the upper address bits. Frames with the other codes belong to the real PHYs on the same wires, and the bridge leaves them alone.

Each 32-bit register appears on the bus as two 16-bit halves. A write of the upper half is held in a staging register. The write of the lower half then commits the whole word as one write request on an internal register bus. On a read, the lower half is fetched first, and that fetch captures the full 32-bit word. The read of the upper half that follows is answered from this captured word, so the two halves always belong to the same value.

The MDC clock and MDIO data are sampled with the system clock through two-stage synchronisers. MDC must therefore be much slower than the system clock.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset the bridge does not drive MDIO (`mdio_oe` low) and issues no register request.
- R2: A write frame whose PHY address bits [4:3] equal 2'b11 loads data bits [9:0] into the page, which becomes register address bits [18:9] for later register frames.
- R3: In a register frame (PHY address bits [4:3] = 2'b10), PHY address bits [2:0] give address bits [8:6] and register field bits [4:1] give address bits [5:2]. `reg_addr[1:0]` is always 0.
- R4: A register-frame write with register field bit 0 = 1 (the upper half) issues no register request and only updates the staging register.
- R5: A register-frame write with register field bit 0 = 0 (the lower half) issues exactly one write request. Its `reg_wdata` is {staged upper half, written lower half}.
- R6: A lower-half read issues one read request and returns `reg_rdata[15:0]`. The following upper-half read issues no request and returns bits [31:16] of the word captured by that lower-half read, even if the register has changed since.
- R7: On a register-frame read the bridge leaves the first turnaround bit undriven, drives the second turnaround bit as 0, then drives 16 data bits MSB first, and then releases the line.
- R8: Frames with PHY address bits [4:3] equal to 2'b00 or 2'b01 cause no register request, no change of the page, and no driving of MDIO.
- R9: A read frame in page mode is not answered: MDIO stays undriven (the pulled-up line reads 16'hFFFF) and no request is issued.
- R10: Reset clears both the page and the staged upper half to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | MDIO management clock from the master |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value driven by the bridge |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| reg_req | output | 1 | One-cycle register-bus request |
| reg_we | output | 1 | Request is a write (1) or read (0) |
| reg_addr | output | PAGE_W+9 | Word-aligned byte address of the request |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Response strobe for a request |
| reg_rdata | input | 32 | Read data, valid with `reg_ack` |

## Verification
The bench sweeps pages and low address fields to their extreme values. A design that shifted the tunnelled PHY bits or the register bits by one place would then hit a wrong address. It changes a register between the two half reads, which catches a bridge that fetches the upper half again and returns a torn word. It writes the upper half on its own and checks that no request appears. A bridge that committed eagerly would let trigger bits in a half-written register fire early. The bench also sends bypass and page-mode reads, and it resets between a staged write and its commit. A bridge that answered foreign PHY frames would cause bus contention. A bridge that kept stale page or staged data through reset would write to the wrong place.

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge #(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              reg_req,
  output logic              reg_we,
  output logic [PAGE_W+8:0] reg_addr,
  output logic [31:0]       reg_wdata,
  input  logic              reg_ack,
  input  logic [31:0]       reg_rdata
);
  localparam logic [1:0] OP_WR = 2'b01, OP_RD = 2'b10;
  localparam logic [1:0] MD_PAGE = 2'b11, MD_REG = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_START, S_HDR, S_TA, S_DATA} st_t;

  st_t               st_q;
  logic [2:0]        mdc_s;
  logic [1:0]        mdi_s;
  logic [11:0]       hdr_q;
  logic [4:0]        cnt_q;
  logic [14:0]       dat_q;
  logic [PAGE_W-1:0] page_q;
  logic [15:0]       stage_q;
  logic [31:0]       hold_q;
  logic              pend_q;

  wire        rise     = mdc_s[1] & ~mdc_s[2];
  wire        bit_in   = mdi_s[1];
  wire [11:0] hdr_nx   = {hdr_q[10:0], bit_in};
  wire [1:0]  op       = hdr_q[11:10];
  wire [1:0]  mode     = hdr_q[9:8];
  wire        rd_frame = (op == OP_RD) && (mode == MD_REG);
  wire [15:0] rd_word  = hdr_q[0] ? hold_q[31:16] : hold_q[15:0];
  wire [15:0] wr_word  = {dat_q, bit_in};

  assign reg_addr = {page_q, hdr_q[7:5], hdr_q[4:1], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_s <= '0;
      mdi_s <= '1;
    end else begin
      mdc_s <= {mdc_s[1:0], mdc};
      mdi_s <= {mdi_s[0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      hdr_q     <= '0;
      cnt_q     <= '0;
      dat_q     <= '0;
      page_q    <= '0;
      stage_q   <= '0;
      hold_q    <= '0;
      pend_q    <= 1'b0;
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
      mdio_oe   <= 1'b0;
      mdio_o    <= 1'b0;
    end else begin
      reg_req <= 1'b0;
      if (reg_ack && pend_q) begin
        hold_q <= reg_rdata;
        pend_q <= 1'b0;
      end
      if (rise) begin
        unique case (st_q)
          S_IDLE:  if (!bit_in) st_q <= S_START;
          S_START: begin
            st_q  <= bit_in ? S_HDR : S_IDLE;
            cnt_q <= '0;
          end
          S_HDR: begin
            hdr_q <= hdr_nx;
            cnt_q <= cnt_q + 5'd1;
            if (cnt_q == 5'd11) begin
              st_q  <= S_TA;
              cnt_q <= '0;
              if (hdr_nx[11:10] == OP_RD && hdr_nx[9:8] == MD_REG && !hdr_nx[0]) begin
                reg_req <= 1'b1;
                reg_we  <= 1'b0;
                pend_q  <= 1'b1;
              end
            end
          end
          S_TA: begin
            if (cnt_q == 5'd0) begin
              cnt_q <= 5'd1;
              if (rd_frame) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              st_q  <= S_DATA;
              cnt_q <= '0;
              if (rd_frame) mdio_o <= rd_word[15];
            end
          end
          S_DATA: begin
            dat_q <= wr_word[14:0];
            cnt_q <= cnt_q + 5'd1;
            if (rd_frame && cnt_q != 5'd15) mdio_o <= rd_word[4'd14 - cnt_q[3:0]];
            if (cnt_q == 5'd15) begin
              st_q    <= S_IDLE;
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b0;
              if (op == OP_WR) begin
                if (mode == MD_PAGE) page_q <= wr_word[PAGE_W-1:0];
                else if (mode == MD_REG) begin
                  if (hdr_q[0]) stage_q <= wr_word;
                  else begin
                    reg_req   <= 1'b1;
                    reg_we    <= 1'b1;
                    reg_wdata <= {stage_q, wr_word};
                  end
                end
              end
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> !mdio_oe);

  p_drive_only_reg_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (op == OP_RD && mode == MD_REG));

  p_req_low_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> (mode == MD_REG && !hdr_q[0]));

  p_page_from_page_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (page_q != $past(page_q)) |-> ($past(hdr_q[9:8]) == MD_PAGE && $past(hdr_q[11:10]) == OP_WR));

  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> (reg_addr[1:0] == 2'b00));
endmodule

// File: tb/mdio_page_bridge_tb.sv
module mdio_page_bridge_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mdc = 0;
  logic        m_oe = 1, m_o = 1;
  logic        mdio_o, mdio_oe, reg_req, reg_we, reg_ack = 0;
  logic [18:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata = '0;
  wire         line = mdio_oe ? mdio_o : (m_oe ? m_o : 1'b1);

  int errors = 0, checks = 0;
  int req_cnt = 0;
  logic [18:0] last_addr = '0;
  logic        last_we = 0;
  logic [31:0] last_wd = '0;
  logic [15:0] bias = 16'h5A5A;

  always #10 clk = ~clk;

  mdio_page_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] model(input logic [18:0] a, input logic [15:0] b);
    return {a[15:0] ^ b, a[15:0]};
  endfunction

  always @(posedge clk) begin
    reg_ack <= 1'b0;
    if (reg_req) begin
      req_cnt   <= req_cnt + 1;
      last_addr <= reg_addr;
      last_we   <= reg_we;
      last_wd   <= reg_wdata;
      reg_ack   <= 1'b1;
      reg_rdata <= model(reg_addr, bias);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mbit(input logic drv, input logic val, output logic smp);
    @(negedge clk) mdc = 0; m_oe = drv; m_o = val;
    repeat (5) @(negedge clk);
    smp = line;
    mdc = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, output logic [15:0] rd, output logic ta);
    logic s;
    logic [13:0] hdr;
    hdr = {2'b01, op, phy, rg};
    for (int i = 0; i < 32; i++) mbit(1, 1, s);
    for (int i = 13; i >= 0; i--) mbit(1, hdr[i], s);
    if (op == 2'b01) begin
      mbit(1, 1, s); mbit(1, 0, s);
      for (int i = 15; i >= 0; i--) mbit(1, wd[i], s);
      rd = '1; ta = 1;
    end else begin
      mbit(0, 1, s); mbit(0, 1, ta);
      for (int i = 15; i >= 0; i--) begin mbit(0, 1, s); rd[i] = s; end
    end
    for (int i = 0; i < 4; i++) mbit(1, 1, s);
    repeat (4) @(negedge clk);
  endtask

  localparam logic [16:0] TBL [6] = '{
    {10'h000, 3'd0, 4'h0}, {10'h3FF, 3'd7, 4'hF}, {10'h155, 3'd2, 4'h5},
    {10'h2AA, 3'd5, 4'hA}, {10'h001, 3'd1, 4'h8}, {10'h200, 3'd4, 4'h1}
  };

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic ta;
    logic [18:0] ea;
    int n;
    repeat (5) @(negedge clk);
    check("R1 oe", {31'b0, mdio_oe}, 0);
    check("R1 req", {31'b0, reg_req}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R1 no req", req_cnt, 0);

    // R2 R3 R6 R7 table sweep
    for (int k = 0; k < 6; k++) begin
      logic [9:0] pg; logic [2:0] pl; logic [3:0] r4;
      {pg, pl, r4} = TBL[k];
      ea = {pg, pl, r4, 2'b00};
      frame(2'b01, 5'b11000, 5'd0, {6'b0, pg}, rd, ta);
      n = req_cnt;
      frame(2'b10, {2'b10, pl}, {r4, 1'b0}, 0, rd, ta);
      check("R2 R3 addr", {13'b0, last_addr}, {13'b0, ea});
      check("R6 one read", req_cnt - n, 1);
      check("R6 low data", {16'b0, rd}, {16'b0, ea[15:0]});
      check("R7 ta", {31'b0, ta}, 0);
      n = req_cnt;
      frame(2'b10, {2'b10, pl}, {r4, 1'b1}, 0, rd, ta);
      check("R6 high data", {16'b0, rd}, {16'b0, ea[15:0] ^ bias});
      check("R6 no req on high", req_cnt - n, 0);
    end

    // R6 coherence: register changes between the halves
    frame(2'b01, 5'b11000, 5'd0, 16'h0123, rd, ta);
    ea = {10'h123, 3'd3, 4'd6, 2'b00};
    frame(2'b10, 5'b10011, 5'b01100, 0, rd, ta);
    bias = 16'h0F0F;
    frame(2'b10, 5'b10011, 5'b01101, 0, rd, ta);
    check("R6 coherent", {16'b0, rd}, {16'b0, ea[15:0] ^ 16'h5A5A});

    // R4 R5 staged write
    n = req_cnt;
    frame(2'b01, 5'b10110, 5'b00111, 16'h1234, rd, ta);
    check("R4 no req", req_cnt - n, 0);
    frame(2'b01, 5'b10110, 5'b00110, 16'hBEEF, rd, ta);
    check("R5 one write", req_cnt - n, 1);
    check("R5 we", {31'b0, last_we}, 1);
    check("R5 data", last_wd, 32'h1234BEEF);
    check("R5 addr", {13'b0, last_addr}, {13'b0, 10'h123, 3'd6, 4'd3, 2'b00});

    // R8 bypass frames
    n = req_cnt;
    frame(2'b01, 5'b00001, 5'd0, 16'h0077, rd, ta);
    frame(2'b01, 5'b01001, 5'd2, 16'h0055, rd, ta);
    frame(2'b10, 5'b00010, 5'd2, 0, rd, ta);
    check("R8 no drive", {15'b0, ta, rd}, {15'b0, 1'b1, 16'hFFFF});
    frame(2'b10, 5'b01010, 5'd4, 0, rd, ta);
    check("R8 no drive m1", {16'b0, rd}, 32'hFFFF);
    check("R8 no req", req_cnt - n, 0);
    frame(2'b10, 5'b10000, 5'd0, 0, rd, ta);
    check("R8 page kept", {22'b0, last_addr[18:9]}, 32'h123);

    // R9 page not readable
    n = req_cnt;
    frame(2'b10, 5'b11000, 5'd0, 0, rd, ta);
    check("R9 undriven", {15'b0, ta, rd}, {15'b0, 1'b1, 16'hFFFF});
    check("R9 no req", req_cnt - n, 0);

    // R10 reset clears page and stage
    frame(2'b01, 5'b10001, 5'b00011, 16'hCAFE, rd, ta);
    frame(2'b01, 5'b11000, 5'd0, 16'h00AB, rd, ta);
    @(negedge clk) rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", {31'b0, mdio_oe}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    frame(2'b01, 5'b10001, 5'b00010, 16'h0011, rd, ta);
    check("R10 stage cleared", last_wd, 32'h00000011);
    check("R10 page cleared", {13'b0, last_addr}, {13'b0, 10'h0, 3'd1, 4'd1, 2'b00});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule